// File: doc/BRIEF.md
# Two-Level Adaptive Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps two tables. The first holds a short outcome history for each branch slot, and that slot is picked by low-order bits of the branch address. The second holds a row of 2-bit saturating counters. The history read from the first table, and not the address, picks which counter gives the guess. A branch whose recent pattern of outcomes repeats can therefore be predicted from that pattern.

A lookup is a two-stage pipeline. The history register of the slot is read and registered first. The registered history then selects a counter, and that counter's upper bit is registered as the answer. A new lookup may start on every cycle. When the branch resolves, the update port trains the tables in a single cycle. The counter that the branch's old history selects moves one step toward the real outcome, and the outcome then enters that slot's history. Target addresses are not produced here.

Top module: `twoLevelPredictor`

## Requirements
- R1: While reset is asserted, `predOutValid` is low. After reset, every history register holds 0 and every counter holds 1, so the first lookups of any address answer not taken (`predTaken` = 0).
- R2: A lookup presented with `predValid` high at clock edge k produces `predOutValid` high with its answer after edge k+2. Lookups may be issued on back-to-back cycles, and each one yields exactly one answer, in issue order.
- R3: The history slot is selected by address bits [7:2] only. Bits [1:0] and bits above 7 have no effect, so addresses that agree in [7:2] share a slot.
- R4: An update shifts the slot's history one place toward the MSB and writes the outcome into the LSB, with 1 for taken and 0 for not taken. The oldest of the 4 bits is dropped, so taken, taken, not taken, not taken leaves the value 4'b1100.
- R5: An update adjusts only the counter indexed by the slot's history as it stood before that update. The counter goes up by one when the outcome is taken and down by one when it is not taken.
- R6: Counters saturate. A taken outcome leaves a counter at 3 unchanged, and a not-taken outcome leaves a counter at 0 unchanged.
- R7: The answer is taken exactly when the selected counter is 2 or 3, which is when its MSB is 1. Values 0 and 1 answer not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| predValid | input | 1 | Start a lookup this cycle |
| predPc | input | 32 | Branch address for the lookup |
| predOutValid | output | 1 | Lookup answer is present |
| predTaken | output | 1 | Answer: 1 taken, 0 not taken |
| updValid | input | 1 | Train the tables this cycle |
| updPc | input | 32 | Address of the resolved branch |
| updTaken | input | 1 | Resolved outcome: 1 taken |

## Verification
The in-module assertions check properties that must hold on every cycle. An answer appears exactly two cycles after its request. Each update moves at most one counter. A counter never wraps at either end, and an unsaturated counter steps by exactly one. Whether the right counter moved, whether the history shifts in the right direction, and whether address bits outside [7:2] are ignored cannot be seen on any single cycle. Only the bench shows these. It trains address slots with repeating outcome patterns, including aliasing addresses, and compares every answer against a model built from the requirements.

// File: rtl/bpPkg.sv
package bpPkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic s1Load;   // capture history of the lookup slot
    logic s2Load;   // capture counter MSB as the answer
    logic tblWe;    // train history and counter tables
    logic tblUp;    // direction of training: 1 = taken
  } bpStrobe_t;

endpackage

// File: rtl/bpSatCounter.sv
module bpSatCounter #(
  parameter int CNT_W    = 2,
  parameter int CNT_INIT = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inc,
  input  logic             dec,
  output logic [CNT_W-1:0] value
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_MIN = '0;
  localparam logic [CNT_W-1:0] CNT_RST = CNT_W'(CNT_INIT);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= CNT_RST;
    end else if (inc && (cnt != CNT_MAX)) begin
      cnt <= cnt + CNT_W'(1);
    end else if (dec && (cnt != CNT_MIN)) begin
      cnt <= cnt - CNT_W'(1);
    end
  end

  assign value = cnt;

  AST_CNT_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(inc && dec));  // R5

  AST_CNT_HOLD_TOP: assert property (@(posedge clk) disable iff (!rstN)
    (inc && cnt == CNT_MAX) |=> (cnt == CNT_MAX));  // R6

  AST_CNT_HOLD_BOT: assert property (@(posedge clk) disable iff (!rstN)
    (dec && cnt == CNT_MIN) |=> (cnt == CNT_MIN));  // R6

  AST_CNT_STEP_UP: assert property (@(posedge clk) disable iff (!rstN)
    (inc && cnt != CNT_MAX) |=> (cnt == $past(cnt) + CNT_W'(1)));  // R5

  AST_CNT_STEP_DN: assert property (@(posedge clk) disable iff (!rstN)
    (dec && cnt != CNT_MIN) |=> (cnt == $past(cnt) - CNT_W'(1)));  // R5

  AST_CNT_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!inc && !dec) |=> $stable(cnt));  // R5

endmodule

// File: rtl/bpCtrl.sv
module bpCtrl
  import bpPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      predValid,
  input  logic      updValid,
  input  logic      updTaken,
  output bpStrobe_t strb,
  output logic      predOutValid
);

  logic s1Valid;
  logic s2Valid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1Valid <= 1'b0;
      s2Valid <= 1'b0;
    end else begin
      s1Valid <= predValid;
      s2Valid <= s1Valid;
    end
  end

  always_comb begin
    strb.s1Load = predValid;
    strb.s2Load = s1Valid;
    strb.tblWe  = updValid;
    strb.tblUp  = updValid && updTaken;
  end

  assign predOutValid = s2Valid;

endmodule

// File: rtl/bpDatapath.sv
module bpDatapath
  import bpPkg::*;
#(
  parameter int HIST_BITS   = 4,
  parameter int SLOT_BITS   = 6,
  parameter int CNT_W       = 2,
  parameter int CNT_INIT    = 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  bpStrobe_t            strb,
  input  logic [SLOT_BITS-1:0] predIdx,
  input  logic [SLOT_BITS-1:0] updIdx,
  output logic                 predTaken
);

  localparam int SLOTS       = 1 << SLOT_BITS;
  localparam int CNT_ENTRIES = 1 << HIST_BITS;

  logic [HIST_BITS-1:0]   histMem [SLOTS];
  logic [HIST_BITS-1:0]   s1Hist;
  logic                   s2Taken;
  logic [HIST_BITS-1:0]   updHist;
  logic [HIST_BITS-1:0]   nextHist;
  logic [CNT_W-1:0]       cntVal [CNT_ENTRIES];
  logic [CNT_ENTRIES-1:0] cntInc;
  logic [CNT_ENTRIES-1:0] cntDec;

  // First level: per-slot outcome history
  assign updHist  = histMem[updIdx];
  assign nextHist = {updHist[HIST_BITS-2:0], strb.tblUp};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SLOTS; s++) begin
        histMem[s] <= '0;
      end
    end else if (strb.tblWe) begin
      histMem[updIdx] <= nextHist;
    end
  end

  // Stage 1: registered history of the lookup slot
  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1Hist <= '0;
    end else if (strb.s1Load) begin
      s1Hist <= histMem[predIdx];
    end
  end

  // Second level: counters indexed by history
  for (genvar i = 0; i < CNT_ENTRIES; i++) begin : gCnt
    assign cntInc[i] = strb.tblWe &&  strb.tblUp && (updHist == HIST_BITS'(i));
    assign cntDec[i] = strb.tblWe && !strb.tblUp && (updHist == HIST_BITS'(i));

    bpSatCounter #(
      .CNT_W    (CNT_W),
      .CNT_INIT (CNT_INIT)
    ) i_cnt (
      .clk   (clk),
      .rstN  (rstN),
      .inc   (cntInc[i]),
      .dec   (cntDec[i]),
      .value (cntVal[i])
    );
  end

  // Stage 2: registered answer from counter MSB
  always_ff @(posedge clk) begin
    if (!rstN) begin
      s2Taken <= 1'b0;
    end else if (strb.s2Load) begin
      s2Taken <= cntVal[s1Hist][CNT_W-1];
    end
  end

  assign predTaken = s2Taken;

  AST_ONE_COUNTER: assert property (@(posedge clk) disable iff (!rstN)
    $countones(cntInc | cntDec) <= 1);  // R5

  AST_TRAIN_MOVES_ONE: assert property (@(posedge clk) disable iff (!rstN)
    strb.tblWe |-> ($countones(cntInc | cntDec) == 1 || $countones(cntInc | cntDec) == 0));  // R5

  AST_NO_TRAIN_NO_MOVE: assert property (@(posedge clk) disable iff (!rstN)
    !strb.tblWe |-> ((cntInc | cntDec) == '0));  // R5

endmodule

// File: rtl/twoLevelPredictor.sv
module twoLevelPredictor
  import bpPkg::*;
#(
  parameter int PC_W      = 32,
  parameter int HIST_BITS = 4,
  parameter int SLOT_BITS = 6,
  parameter int CNT_W     = 2,
  parameter int CNT_INIT  = 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            predValid,
  input  logic [PC_W-1:0] predPc,
  output logic            predOutValid,
  output logic            predTaken,
  input  logic            updValid,
  input  logic [PC_W-1:0] updPc,
  input  logic            updTaken
);

  localparam int IDX_LO = 2;
  localparam int IDX_HI = IDX_LO + SLOT_BITS - 1;

  bpStrobe_t            strb;
  logic [SLOT_BITS-1:0] predIdx;
  logic [SLOT_BITS-1:0] updIdx;
  logic                 unusedPcBits;

  assign predIdx = predPc[IDX_HI:IDX_LO];
  assign updIdx  = updPc[IDX_HI:IDX_LO];
  assign unusedPcBits = ^{predPc[PC_W-1:IDX_HI+1], predPc[IDX_LO-1:0],
                          updPc[PC_W-1:IDX_HI+1], updPc[IDX_LO-1:0]};

  bpCtrl i_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .predValid    (predValid),
    .updValid     (updValid),
    .updTaken     (updTaken),
    .strb         (strb),
    .predOutValid (predOutValid)
  );

  bpDatapath #(
    .HIST_BITS (HIST_BITS),
    .SLOT_BITS (SLOT_BITS),
    .CNT_W     (CNT_W),
    .CNT_INIT  (CNT_INIT)
  ) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .predIdx   (predIdx),
    .updIdx    (updIdx),
    .predTaken (predTaken)
  );

  AST_PRED_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    predOutValid |-> $past(predValid, 2));  // R2

  AST_REQ_ANSWERED: assert property (@(posedge clk) disable iff (!rstN)
    (predValid && $past(rstN)) |=> ##1 predOutValid);  // R2

endmodule

// File: tb/test_twoLevelPredictor.sv
module test_twoLevelPredictor;

  localparam int  CLK_PS = 5000;   // 200 MHz
  localparam int  PC_W   = 32;

  typedef struct {
    bit    taken;
    int    cycle;
    string req;
  } expItem_t;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            predValid = 1'b0;
  logic [PC_W-1:0] predPc = '0;
  logic            predOutValid;
  logic            predTaken;
  logic            updValid = 1'b0;
  logic [PC_W-1:0] updPc = '0;
  logic            updTaken = 1'b0;

  int checks = 0;
  int errors = 0;
  int cycleCnt = 0;
  bit done = 1'b0;

  expItem_t expQ[$];
  bit [3:0] refHist [64];
  int       refCnt  [16];

  always #(CLK_PS/2) clk = ~clk;
  always @(posedge clk) cycleCnt <= cycleCnt + 1;

  twoLevelPredictor i_twoLevelPredictor (
    .clk          (clk),
    .rstN         (rstN),
    .predValid    (predValid),
    .predPc       (predPc),
    .predOutValid (predOutValid),
    .predTaken    (predTaken),
    .updValid     (updValid),
    .updPc        (updPc),
    .updTaken     (updTaken)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit refPredict(input logic [PC_W-1:0] pc);
    return refCnt[refHist[pc[7:2]]] >= 2;
  endfunction

  // Driver: one lookup per call, leaves predValid high for back-to-back use
  task automatic predictOne(input logic [PC_W-1:0] pc, input string req);
    expItem_t it;
    @(negedge clk);
    predValid = 1'b1;
    predPc    = pc;
    it.taken  = refPredict(pc);
    it.cycle  = cycleCnt + 2;
    it.req    = req;
    expQ.push_back(it);
  endtask

  task automatic predIdle();
    @(negedge clk);
    predValid = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic train(input logic [PC_W-1:0] pc, input bit taken);
    bit [3:0] h;
    @(negedge clk);
    updValid = 1'b1;
    updPc    = pc;
    updTaken = taken;
    h = refHist[pc[7:2]];
    if (taken && refCnt[h] < 3) refCnt[h]++;
    else if (!taken && refCnt[h] > 0) refCnt[h]--;
    refHist[pc[7:2]] = {h[2:0], taken};
    @(negedge clk);
    updValid = 1'b0;
  endtask

  // Monitor: pops expected answers as the design produces them
  always @(negedge clk) begin
    if (rstN && predOutValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R2 unexpected answer", 1, 0);
      end else begin
        expItem_t it;
        it = expQ.pop_front();
        check(predTaken == it.taken, it.req, int'(predTaken), int'(it.taken));
        check(cycleCnt == it.cycle, "R2 latency", cycleCnt, it.cycle);
      end
    end
  end

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PS * 200000);
    if (!done) begin
      check(1'b0, "watchdog", 0, 1);
      finishRun();
    end
  end

  initial begin
    for (int s = 0; s < 64; s++) refHist[s] = '0;
    for (int c = 0; c < 16; c++) refCnt[c] = 1;

    repeat (4) @(negedge clk);
    check(predOutValid == 1'b0, "R1 valid low in reset", int'(predOutValid), 0);
    rstN = 1'b1;

    // R1: fresh tables answer not taken; R2: back-to-back lookups
    predictOne(32'h0000_0000, "R1 reset answer");
    predictOne(32'h0000_00FC, "R1 reset answer");
    predictOne(32'h1234_5678, "R1 reset answer");
    predIdle();

    // R4/R5/R7: four taken outcomes walk history 0000->1111, counters 0,1,3,7 rise
    for (int k = 0; k < 4; k++) train(32'h0000_0040, 1'b1);
    predictOne(32'h0000_0040, "R4 history 1111 uses untouched counter");
    predIdle();
    // slot 0x44 history 0000 -> counter 0 now 2, taken
    predictOne(32'h0000_0044, "R7 counter 2 answers taken");
    predIdle();

    // R3: aliasing addresses share slot 0x10 (bits above 7, bits 1:0 differ)
    predictOne(32'hABCD_0043, "R3 alias of trained slot");
    predIdle();
    train(32'h0000_0143, 1'b0);  // same slot as 0x40
    predictOne(32'h0000_0040, "R3 alias update seen");
    predIdle();

    // R6: saturation at the top, then at the bottom
    for (int k = 0; k < 6; k++) train(32'h0000_0080, 1'b1);
    for (int k = 0; k < 8; k++) train(32'h0000_0084, 1'b0);
    predictOne(32'h0000_0080, "R6 saturated high");
    predictOne(32'h0000_0084, "R6 saturated low");
    predictOne(32'h0000_0088, "R6 untouched slot");
    predIdle();
    for (int k = 0; k < 2; k++) train(32'h0000_0084, 1'b1);
    predictOne(32'h0000_0084, "R6 climb from zero");
    predIdle();

    // R4/R5: repeating taken,taken,not,not pattern is learned per phase
    for (int r = 0; r < 6; r++) begin
      train(32'h0000_00C0, 1'b1);
      train(32'h0000_00C0, 1'b1);
      train(32'h0000_00C0, 1'b0);
      train(32'h0000_00C0, 1'b0);
    end
    for (int ph = 0; ph < 4; ph++) begin
      predictOne(32'h0000_00C0, "R4 pattern phase");
      predIdle();
      train(32'h0000_00C0, (ph < 2));
    end

    // R5: other slot with same history sees shared counter
    predictOne(32'h0000_00D0, "R5 counter shared by history");
    predIdle();

    // R2: long back-to-back burst over many slots
    for (int k = 0; k < 20; k++) predictOne(PC_W'(k * 4 + 32'h100), "R2 burst");
    predIdle();

    check(expQ.size() == 0, "R2 all answered", expQ.size(), 0);
    done = 1'b1;
    finishRun();
  end

endmodule